// File: doc/BRIEF.md
# Instruction Fetch Segment Buffer

This block sits between the fetch-address generator and the instruction memory of a multi-threaded core. Each hardware thread owns one buffer that holds a naturally aligned segment of instruction bytes. The segment is smaller than, or equal to, an instruction-cache line. Every cycle the caller presents a thread number and a fetch address. If the address falls inside that thread's filled segment, the block returns up to a fixed number of 32-bit instruction words, in address order, starting at the word the address points to. If it does not, the block asks memory for the aligned segment that contains the address.

The block also looks one step ahead. After a hit, it works out where fetch will continue. When that point lies in a different segment, it asks for that segment at once, so the following access does not stall for the full memory latency. Each thread may have only one read outstanding. A thread can be told that its outstanding read has been overtaken by a redirect. When that read returns, its data is thrown away.

All outputs are combinational from the current inputs and the stored state. Tags, fill flags and data change only at the rising clock edge.

Top module: `fetch_buffer`

## Requirements
- R1: The segment size `BUF_BYTES` defaults to 64 bytes and the line size `LINE_BYTES` defaults to 64 bytes. Elaboration fails unless all of these hold: `BUF_BYTES` is a power of two, it is at least 8, it does not exceed `LINE_BYTES`, and it divides `LINE_BYTES` exactly. `memReqLen` always equals `BUF_BYTES`.
- R2: A request address is the triggering address with its low log2(`BUF_BYTES`) bits forced to zero.
- R3: When a request is accepted (`memReqValid` and `memReqReady` both high), the block does two things at that edge: it stores the request address as the thread's tag, and it marks the thread's segment as not filled. From the next cycle, a fetch in the previously held segment misses.
- R4: A response for a thread with a read outstanding, and not marked stale, writes `memRspData` into that thread's buffer and marks it filled. Word i of the segment is taken from bits [32i+31:32i] of `memRspData`.
- R5: A hit needs three things: `fetchValid`, a filled segment for `fetchTid`, and a tag equal to the aligned fetch address. On a miss `instCount` is 0 and `instWords` is all zero.
- R6: On a hit, the word offset is (fetch address − tag)/4. `instCount` is the smaller of `FETCH_WIDTH` (default 8) and the number of words from that offset to the end of the segment. Lane k of `instWords` (bits [32k+31:32k]) carries the word at offset+k; lanes at or above `instCount` are zero.
- R7: On a hit, the next address is the fetch address plus 4·`instCount`. If the aligned next address differs from the tag, the block requests that aligned next address (an early fetch).
- R8: No request is raised for a thread that has a read outstanding, or whose `xlatWait` bit is set. A request that `memReqReady` does not accept changes no state, and it is raised again while its condition holds.
- R9: At most one read per thread is outstanding. A response for a thread with nothing outstanding is ignored: the thread's data and fill flag are unchanged.
- R10: A `redirect` for a thread with a read outstanding marks that read stale. The same applies when `redirect` arrives in the same cycle as the response. A stale response clears the outstanding state but does not mark the segment filled.
- R11: Reset (synchronous, active high) clears every tag to zero and every fill flag. After reset, a fetch of address 0 misses and requests address 0.
- R12: Threads are independent. One thread's tag, fill flag, outstanding read and stale mark do not affect another thread's hits or requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetchValid | input | 1 | A fetch is presented this cycle |
| fetchTid | input | TID_W | Thread of the fetch |
| fetchAddr | input | ADDR_W | Byte address of the fetch (word aligned) |
| xlatWait | input | NT | Per-thread flag: address translation is pending |
| redirect | input | 1 | The outstanding read of `redirectTid` is overtaken |
| redirectTid | input | TID_W | Thread being redirected |
| memReqValid | output | 1 | Segment read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqTid | output | TID_W | Thread of the request |
| memReqAddr | output | ADDR_W | Segment-aligned request address |
| memReqLen | output | LEN_W | Request length in bytes (BUF_BYTES) |
| memRspValid | input | 1 | Read data returns |
| memRspTid | input | TID_W | Thread of the returning data |
| memRspData | input | BUF_BYTES*8 | Segment data, word i at bits [32i+31:32i] |
| instCount | output | CNT_W | Number of words delivered this cycle |
| instWords | output | FETCH_WIDTH*32 | Delivered words, lane k at bits [32k+31:32k] |

## Verification
The hardest state to reach is a response that returns after its read was superseded. To reach it, a thread must first have a read accepted. A redirect must then land while that read is still outstanding. Only after that can the response be allowed through. The stimulus holds the response back by hand. It fires the redirect on an idle cycle in one case and in the same cycle as the response in another. It then fetches from the same address to show that the segment stayed unfilled, and that a new request appears. Early fetches are exercised the same way. `memReqReady` is held low while the fetch address is swept across every word offset of a filled segment, so each cross-boundary request is seen without being accepted and without changing the state.

// File: rtl/fetch_buffer_pkg.sv
package fetch_buffer_pkg;

  // Instruction word size in bytes; the buffer is addressed in these units.
  localparam int INST_BYTES = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic tagWr;   // capture request address as the thread's tag
    logic fillWr;  // write response data into the thread's buffer
  } dpStrobeT;

endpackage

// File: rtl/fetch_buffer_ctrl.sv
module fetch_buffer_ctrl
  import fetch_buffer_pkg::*;
#(
  parameter int NT          = 2,
  parameter int ADDR_W      = 32,
  parameter int BUF_BYTES   = 64,
  parameter int FETCH_WIDTH = 8,
  localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int WORDS   = BUF_BYTES / INST_BYTES,
  localparam int SEG_LSB = $clog2(BUF_BYTES),
  localparam int OFF_W   = SEG_LSB - 2,
  localparam int CNT_W   = $clog2(FETCH_WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchValid,
  input  logic [TID_W-1:0]  fetchTid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [NT-1:0]     xlatWait,
  input  logic              redirect,
  input  logic [TID_W-1:0]  redirectTid,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [TID_W-1:0]  memRspTid,
  input  logic [ADDR_W-1:0] selPc,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [TID_W-1:0]  memReqTid,
  output logic [CNT_W-1:0]  instCount,
  output logic [OFF_W-1:0]  wordOff,
  output dpStrobeT          strobe
);

  localparam logic [ADDR_W-1:0] SEG_MASK = ADDR_W'(BUF_BYTES - 1);

  logic [NT-1:0] validQ;
  logic [NT-1:0] pendQ;
  logic [NT-1:0] staleQ;

  logic [ADDR_W-1:0] alignFetch;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] alignNext;
  logic [OFF_W:0]    room;
  logic              hit;
  logic              early;
  logic              want;
  logic              blocked;
  logic              accept;
  logic              rspLive;
  logic              rspDrop;

  assign alignFetch = fetchAddr & ~SEG_MASK;
  assign wordOff    = fetchAddr[SEG_LSB-1:2];
  assign hit        = fetchValid && validQ[fetchTid] && (alignFetch == selPc);
  assign room       = (OFF_W+1)'(WORDS) - {1'b0, wordOff};

  always_comb begin
    instCount = '0;
    if (hit) begin
      if (int'(room) > FETCH_WIDTH) instCount = CNT_W'(FETCH_WIDTH);
      else                          instCount = CNT_W'(room);
    end
  end

  assign nextAddr  = fetchAddr + (ADDR_W'(instCount) << 2);
  assign alignNext = nextAddr & ~SEG_MASK;
  assign early     = hit && (alignNext != selPc);
  assign want      = (fetchValid && !hit) || early;
  assign blocked   = pendQ[fetchTid] || xlatWait[fetchTid];

  assign memReqValid = want && !blocked;
  assign memReqAddr  = hit ? alignNext : alignFetch;
  assign memReqTid   = fetchTid;

  assign accept  = memReqValid && memReqReady;
  assign rspLive = memRspValid && pendQ[memRspTid];
  assign rspDrop = staleQ[memRspTid] || (redirect && (redirectTid == memRspTid));

  assign strobe.tagWr  = accept;
  assign strobe.fillWr = rspLive && !rspDrop;

  for (genvar t = 0; t < NT; t++) begin : gThread
    always_ff @(posedge clk) begin
      if (rst) begin
        validQ[t] <= 1'b0;
        pendQ[t]  <= 1'b0;
        staleQ[t] <= 1'b0;
      end else if (accept && (fetchTid == TID_W'(t))) begin
        validQ[t] <= 1'b0;
        pendQ[t]  <= 1'b1;
        staleQ[t] <= 1'b0;
      end else begin
        if (rspLive && (memRspTid == TID_W'(t))) begin
          pendQ[t] <= 1'b0;
          if (!rspDrop) validQ[t] <= 1'b1;
        end
        if (redirect && (redirectTid == TID_W'(t)) && pendQ[t])
          staleQ[t] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fetch_buffer_dp.sv
module fetch_buffer_dp
  import fetch_buffer_pkg::*;
#(
  parameter int NT          = 2,
  parameter int ADDR_W      = 32,
  parameter int BUF_BYTES   = 64,
  parameter int FETCH_WIDTH = 8,
  localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int WORDS   = BUF_BYTES / INST_BYTES,
  localparam int SEG_LSB = $clog2(BUF_BYTES),
  localparam int OFF_W   = SEG_LSB - 2,
  localparam int CNT_W   = $clog2(FETCH_WIDTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpStrobeT                 strobe,
  input  logic [TID_W-1:0]         reqTid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [TID_W-1:0]         rspTid,
  input  logic [BUF_BYTES*8-1:0]   rspData,
  input  logic [TID_W-1:0]         selTid,
  input  logic [OFF_W-1:0]         wordOff,
  input  logic [CNT_W-1:0]         instCount,
  output logic [ADDR_W-1:0]        selPc,
  output logic [FETCH_WIDTH*32-1:0] instWords
);

  logic [ADDR_W-1:0] bufPc    [NT];
  logic [31:0]       bufWords [NT][WORDS];

  for (genvar t = 0; t < NT; t++) begin : gTag
    always_ff @(posedge clk) begin
      if (rst)                                           bufPc[t] <= '0;
      else if (strobe.tagWr && (reqTid == TID_W'(t)))    bufPc[t] <= reqAddr;
    end

    for (genvar w = 0; w < WORDS; w++) begin : gWord
      always_ff @(posedge clk) begin
        if (strobe.fillWr && (rspTid == TID_W'(t)))
          bufWords[t][w] <= rspData[w*32 +: 32];
      end
    end
  end

  assign selPc = bufPc[selTid];

  for (genvar k = 0; k < FETCH_WIDTH; k++) begin : gLane
    logic [OFF_W:0] idx;
    assign idx = {1'b0, wordOff} + (OFF_W+1)'(k);
    assign instWords[k*32 +: 32] =
      (CNT_W'(k) < instCount) ? bufWords[selTid][idx[OFF_W-1:0]] : 32'h0;
  end

endmodule

// File: rtl/fetch_buffer.sv
module fetch_buffer
  import fetch_buffer_pkg::*;
#(
  parameter int NT          = 2,
  parameter int ADDR_W      = 32,
  parameter int BUF_BYTES   = 64,
  parameter int LINE_BYTES  = 64,
  parameter int FETCH_WIDTH = 8,
  localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int SEG_LSB = $clog2(BUF_BYTES),
  localparam int OFF_W   = SEG_LSB - 2,
  localparam int CNT_W   = $clog2(FETCH_WIDTH + 1),
  localparam int LEN_W   = SEG_LSB + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fetchValid,
  input  logic [TID_W-1:0]          fetchTid,
  input  logic [ADDR_W-1:0]         fetchAddr,
  input  logic [NT-1:0]             xlatWait,
  input  logic                      redirect,
  input  logic [TID_W-1:0]          redirectTid,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [TID_W-1:0]          memReqTid,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [LEN_W-1:0]          memReqLen,
  input  logic                      memRspValid,
  input  logic [TID_W-1:0]          memRspTid,
  input  logic [BUF_BYTES*8-1:0]    memRspData,
  output logic [CNT_W-1:0]          instCount,
  output logic [FETCH_WIDTH*32-1:0] instWords
);

  if (BUF_BYTES < 8 || (BUF_BYTES & (BUF_BYTES - 1)) != 0 ||
      BUF_BYTES > LINE_BYTES || (LINE_BYTES % BUF_BYTES) != 0) begin : gBadCfg
    $error("fetch_buffer: segment size must be a power of two >= 8 dividing the line size");
  end

  dpStrobeT          strobe;
  logic [ADDR_W-1:0] selPc;
  logic [OFF_W-1:0]  wordOff;

  assign memReqLen = LEN_W'(BUF_BYTES);

  fetch_buffer_ctrl #(
    .NT(NT), .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .FETCH_WIDTH(FETCH_WIDTH)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .fetchValid(fetchValid), .fetchTid(fetchTid), .fetchAddr(fetchAddr),
    .xlatWait(xlatWait), .redirect(redirect), .redirectTid(redirectTid),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspTid(memRspTid),
    .selPc(selPc),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqTid(memReqTid),
    .instCount(instCount), .wordOff(wordOff), .strobe(strobe)
  );

  fetch_buffer_dp #(
    .NT(NT), .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .FETCH_WIDTH(FETCH_WIDTH)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqTid(memReqTid), .reqAddr(memReqAddr),
    .rspTid(memRspTid), .rspData(memRspData),
    .selTid(fetchTid), .wordOff(wordOff), .instCount(instCount),
    .selPc(selPc), .instWords(instWords)
  );

endmodule

// File: rtl/fetch_buffer_chk.sv
module fetch_buffer_chk #(
  parameter int NT          = 2,
  parameter int ADDR_W      = 32,
  parameter int BUF_BYTES   = 64,
  parameter int FETCH_WIDTH = 8,
  localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int SEG_LSB = $clog2(BUF_BYTES),
  localparam int WORDS   = BUF_BYTES / 4,
  localparam int CNT_W   = $clog2(FETCH_WIDTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [TID_W-1:0]  memReqTid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [TID_W-1:0]  memRspTid,
  input logic [CNT_W-1:0]  instCount
);

  // Independent record of reads in flight, one flag per thread.
  logic [NT-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else begin
      if (memRspValid) inFlight[memRspTid] <= 1'b0;
      if (memReqValid && memReqReady) inFlight[memReqTid] <= 1'b1;
    end
  end

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> (memReqAddr[SEG_LSB-1:0] == '0));

  p_single_read_r9: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> !inFlight[memReqTid]);

  p_width_cap_r6: assert property (@(posedge clk) disable iff (rst)
    int'(instCount) <= FETCH_WIDTH);

  p_segment_end_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(instCount) + int'(fetchAddr[SEG_LSB-1:2])) <= WORDS || instCount == '0);

  p_idle_no_words_r5: assert property (@(posedge clk) disable iff (rst)
    !fetchValid |-> (instCount == '0));

  p_reset_empty_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (instCount == '0));

endmodule

bind fetch_buffer fetch_buffer_chk #(
  .NT(NT), .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .FETCH_WIDTH(FETCH_WIDTH)
) uChk (
  .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqTid(memReqTid),
  .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspTid(memRspTid),
  .instCount(instCount)
);

// File: tb/fetch_buffer_test.sv
module fetch_buffer_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fetchValid = 1'b0;
  logic [0:0]   fetchTid = '0;
  logic [31:0]  fetchAddr = '0;
  logic [1:0]   xlatWait = '0;
  logic         redirect = 1'b0;
  logic [0:0]   redirectTid = '0;
  logic         memReqValid;
  logic         memReqReady = 1'b1;
  logic [0:0]   memReqTid;
  logic [31:0]  memReqAddr;
  logic [6:0]   memReqLen;
  logic         memRspValid = 1'b0;
  logic [0:0]   memRspTid = '0;
  logic [511:0] memRspData = '0;
  logic [3:0]   instCount;
  logic [255:0] instWords;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // Behavioural reference state, indexed by thread.
  logic [31:0] mPc   [2];
  logic [31:0] mBase [2];
  bit          mFill [2];
  bit          mPend [2];
  bit          mStale[2];

  always #5 clk = ~clk;

  fetch_buffer uut (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchTid(fetchTid),
    .fetchAddr(fetchAddr), .xlatWait(xlatWait), .redirect(redirect),
    .redirectTid(redirectTid), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqTid(memReqTid), .memReqAddr(memReqAddr), .memReqLen(memReqLen),
    .memRspValid(memRspValid), .memRspTid(memRspTid), .memRspData(memRspData),
    .instCount(instCount), .instWords(instWords)
  );

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h0F0F_1234;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  task automatic cycle(input bit fv, input int tid, input logic [31:0] a,
                       input bit [1:0] xw, input bit rdy,
                       input bit rv, input int rt, input logic [31:0] ra,
                       input bit rd, input int rdt, input string tag);
    bit hit, early, ev, okReq, okDel;
    int off, cnt;
    logic [31:0] nxt, ea;
    logic [255:0] ew;
    fetchValid = fv; fetchTid = 1'(tid); fetchAddr = a; xlatWait = xw;
    memReqReady = rdy; memRspValid = rv; memRspTid = 1'(rt);
    redirect = rd; redirectTid = 1'(rdt);
    for (int i = 0; i < 16; i++) memRspData[i*32 +: 32] = memWord(ra + 32'(4*i));
    #1;
    hit   = fv && mFill[tid] && ((a & ~32'h3F) == mPc[tid]);
    off   = int'((a & 32'h3F) >> 2);
    cnt   = hit ? (((16 - off) < 8) ? (16 - off) : 8) : 0;
    nxt   = a + 32'(4 * cnt);
    early = hit && ((nxt & ~32'h3F) != mPc[tid]);
    ev    = ((fv && !hit) || early) && !mPend[tid] && !xw[tid];
    ea    = hit ? (nxt & ~32'h3F) : (a & ~32'h3F);
    ew    = '0;
    for (int k = 0; k < cnt; k++) ew[k*32 +: 32] = memWord(mBase[tid] + 32'(4 * (off + k)));

    vectors++;
    okReq = (memReqValid == ev) && (memReqLen == 7'd64) &&
            (!ev || (memReqAddr == ea && int'(memReqTid) == tid));
    if (!okReq) begin
      misses++;
      $display("FAIL %s request: actual v=%0b a=%h t=%0d len=%0d expected v=%0b a=%h t=%0d len=64",
               tag, memReqValid, memReqAddr, memReqTid, memReqLen, ev, ea, tid);
    end
    vectors++;
    okDel = (int'(instCount) == cnt) && (instWords == ew);
    if (!okDel) begin
      misses++;
      $display("FAIL %s delivery: actual n=%0d w=%h expected n=%0d w=%h",
               tag, instCount, instWords, cnt, ew);
    end

    @(posedge clk);
    if (rv && mPend[rt]) begin
      mPend[rt] = 0;
      if (!mStale[rt] && !(rd && rdt == rt)) begin
        mFill[rt] = 1; mBase[rt] = ra;
      end
    end
    if (rd && mPend[rdt]) mStale[rdt] = 1;
    if (ev && rdy) begin
      mPc[tid] = ea; mFill[tid] = 0; mPend[tid] = 1; mStale[tid] = 0;
    end
    @(negedge clk);
  endtask

  task automatic fetch(input int tid, input logic [31:0] a, input string tag);
    cycle(1, tid, a, 2'b00, 1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic respond(input int rt, input logic [31:0] ra, input string tag);
    cycle(0, 0, 0, 2'b00, 1, 1, rt, ra, 0, 0, tag);
  endtask

  initial begin
    for (int t = 0; t < 2; t++) begin
      mPc[t] = 0; mBase[t] = 0; mFill[t] = 0; mPend[t] = 0; mStale[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    cycle(0, 0, 0, 2'b00, 1, 0, 0, 0, 0, 0, "R11");      // idle after reset
    fetch(0, 32'h0, "R11");                               // tag 0 but unfilled: miss
    fetch(0, 32'h0, "R9");                                // outstanding: no second read
    cycle(1, 0, 32'h0, 2'b00, 1, 1, 0, 32'h0, 0, 0, "R4");// fill arrives
    fetch(0, 32'h0, "R6");                                // eight words from offset 0
    fetch(0, 32'h20, "R7");                               // crosses end: early read 0x40
    fetch(0, 32'h20, "R3");                               // old segment now unfilled
    cycle(1, 0, 32'h40, 2'b00, 1, 1, 0, 32'h40, 0, 0, "R4");
    cycle(1, 0, 32'h74, 2'b00, 0, 0, 0, 0, 0, 0, "R6");   // three words, early not accepted
    cycle(1, 0, 32'h74, 2'b00, 0, 0, 0, 0, 0, 0, "R8");   // still raised on retry
    cycle(1, 0, 32'h74, 2'b01, 1, 0, 0, 0, 0, 0, "R8");   // translation wait suppresses
    fetch(0, 32'h48, "R6");                               // offset 2, stays in segment
    fetch(0, 32'h1234, "R2");                             // unaligned: request 0x1200
    fetch(1, 32'h2000, "R12");                            // other thread not blocked
    cycle(1, 1, 32'h2000, 2'b00, 1, 0, 0, 0, 1, 1, "R10");// redirect while outstanding
    cycle(1, 1, 32'h2000, 2'b00, 1, 1, 1, 32'h2000, 0, 0, "R10");
    fetch(1, 32'h2000, "R10");                            // stale dropped: new request
    cycle(1, 1, 32'h2000, 2'b00, 1, 1, 0, 32'h1200, 0, 0, "R12");
    fetch(0, 32'h1230, "R12");                            // thread 0 hit at offset 12
    cycle(0, 0, 0, 2'b00, 1, 1, 1, 32'h2000, 1, 1, "R10");// redirect with response: drop
    fetch(1, 32'h2004, "R10");                            // still unfilled, new read
    respond(1, 32'h2000, "R4");
    respond(1, 32'h3000, "R9");                           // nothing outstanding: ignored
    fetch(1, 32'h2004, "R9");                             // original data delivered
    fetch(1, 32'h2040, "R5");                             // tag mismatch
    respond(1, 32'h2040, "R4");
    for (int o = 0; o < 16; o++)
      cycle(1, 1, 32'h2040 + 32'(4*o), 2'b00, 0, 0, 0, 0, 0, 0, "R6");
    cycle(1, 1, 32'h2048, 2'b10, 0, 0, 0, 0, 0, 0, "R1");
    cycle(0, 1, 32'h2048, 2'b00, 1, 0, 0, 0, 0, 0, "R5"); // no fetch: nothing delivered

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

endmodule